// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Unit

This unit gathers the eight interrupt conditions of an enhanced UART and ranks them by fixed priority. The winner is encoded into an 8-bit status byte. The host captures that byte with a read strobe, and a single interrupt line tells the host that service is needed. Some sources are level conditions that track their input directly: line errors, receive timeout, receive data, modem change and general-purpose input change. The others are latched events with their own clear rules: transmit empty, Xoff match, special-character match and flow-control (CTS/RTS) de-assertion.

The unit also holds the FIFO control byte. Its low bit is the FIFO enable, and that bit is mirrored into the top two bits of the status byte. The upper control bits change only when a write also sets the enable bit.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, `isr_q` is 8'h01, `fcr_q` is 0 and `irq` is 0.
- R2: Priority runs from highest to lowest as: line error, receive timeout, receive ready, transmit empty, modem change, general-purpose change, Xoff/special character, flow change. `isr_q[5:0]` gives the winner's code: 0x06, 0x0C, 0x04, 0x02, 0x00, 0x30, 0x10 and 0x20 in that order, or 0x01 when nothing is pending.
- R3: `int_en[i]` gates source i, where i is its rank in R2 counting from 0. A disabled source neither raises `irq` nor appears in `isr_q`. With the default options, `irq` is high in the same cycle that any enabled source is pending.
- R4: Line error, receive timeout, receive ready, modem change and general-purpose change are not latched. They stop being pending as soon as their input goes low.
- R5: A 0-to-1 change of `tx_empty` latches a transmit event. The event clears when a read reports code 0x02. If a new rising edge arrives in the same cycle as that clearing read, the event stays set.
- R6: An Xoff match is latched only while `enh_en` and `int_en[6]` are both 1. It reports code 0x10 (bit 4) across any number of reads and clears only on `xon_hit`.
- R7: A special-character match is latched under the same enables as R6. It reports code 0x10 and clears when a read reports 0x10.
- R8: A flow-control de-assertion is latched only while `enh_en` is 1, and it is pending only while `enh_en` and `int_en[7]` are both 1. It reports code 0x20 and clears when a read reports 0x20.
- R9: `isr_q` changes only at a clock edge where `stat_rd` is high. At that edge it captures the current status, with bits 7:6 both equal to `fcr_q[0]`.
- R10: A write to the FIFO control byte always updates bit 0. Bits above bit 0 are updated only when bit 0 of the written data is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_err | input | 1 | Line error condition (level) |
| rx_timeout | input | 1 | Receive timeout condition (level) |
| rx_ready | input | 1 | Receive data ready (level) |
| tx_empty | input | 1 | Transmitter empty (rising edge latched) |
| modem_chg | input | 1 | Modem status change (level) |
| gpin_chg | input | 1 | General-purpose input change (level) |
| xoff_hit | input | 1 | Xoff character matched (pulse) |
| spchr_hit | input | 1 | Special character matched (pulse) |
| flow_deassert | input | 1 | CTS or RTS de-asserted (pulse) |
| xon_hit | input | 1 | Xon character received (pulse) |
| int_en | input | 8 | Per-source interrupt enables, indexed by rank |
| enh_en | input | 1 | Enhanced-feature enable |
| stat_rd | input | 1 | Status read strobe |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | FCR_W | FIFO control write data |
| isr_q | output | 8 | Captured status byte |
| fcr_q | output | FCR_W | FIFO control byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two of the unit's functions can fall in the same cycle: a status read that clears a latched event, and a new occurrence of that same event. The bench provokes this by reading while transmit is the reported source, while `tx_empty` rises in that same cycle. It expects a second read to report 0x02 again. A behavioural model applies clears before sets on every edge, and the bench compares `isr_q`, `fcr_q` and `irq` against it on every clock, both in directed sequences and in long random runs where reads, pulses and Xon arrive together.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int NSRC = 8;
   localparam int SRC_IW = $clog2(NSRC);

   // rank order is the arbitration order: lower value wins
   typedef enum logic [SRC_IW-1:0] {
      SRC_LINE  = 3'd0,
      SRC_RXTO  = 3'd1,
      SRC_RXRDY = 3'd2,
      SRC_TXRDY = 3'd3,
      SRC_MODEM = 3'd4,
      SRC_GPIN  = 3'd5,
      SRC_XCHR  = 3'd6,
      SRC_FLOW  = 3'd7
   } src_e;

   // latched event slots
   localparam int EV_TX   = 0;
   localparam int EV_XOFF = 1;
   localparam int EV_SPC  = 2;
   localparam int EV_FLOW = 3;
   localparam int NEV     = 4;

   function automatic logic [5:0] src_code(input logic any, input logic [SRC_IW-1:0] idx);
      if (!any) return 6'h01;
      case (idx)
         SRC_LINE:  return 6'h06;
         SRC_RXTO:  return 6'h0C;
         SRC_RXRDY: return 6'h04;
         SRC_TXRDY: return 6'h02;
         SRC_MODEM: return 6'h00;
         SRC_GPIN:  return 6'h30;
         SRC_XCHR:  return 6'h10;
         default:   return 6'h20;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_evt.sv
module uart_irq_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // a fresh event in the clearing cycle is kept
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_rank
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/uart_irq_fcr.sv
module uart_irq_fcr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr) begin
         q[0] <= wdata[0];
         if (wdata[0]) q[W-1:1] <= wdata[W-1:1];
      end
   end

   assert_keep_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr && !wdata[0] |=> q[W-1:1] == $past(q[W-1:1]));
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
   import uart_irq_pkg::*;
#(
   parameter int FCR_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_err,
   input  logic             rx_timeout,
   input  logic             rx_ready,
   input  logic             tx_empty,
   input  logic             modem_chg,
   input  logic             gpin_chg,
   input  logic             xoff_hit,
   input  logic             spchr_hit,
   input  logic             flow_deassert,
   input  logic             xon_hit,
   input  logic [NSRC-1:0]  int_en,
   input  logic             enh_en,
   input  logic             stat_rd,
   input  logic             fcr_wr,
   input  logic [FCR_W-1:0] fcr_wdata,
   output logic [7:0]       isr_q,
   output logic [FCR_W-1:0] fcr_q,
   output logic             irq
);
   initial begin
      assert_fcr_width_R10: assert (FCR_W >= 2)
         else $error("FCR_W must be at least 2");
   end

   logic              tx_prev;
   logic [NEV-1:0]    ev_set, ev_clr, ev_q;
   logic [NSRC-1:0]   pend, grant;
   logic [SRC_IW-1:0] win_idx;
   logic              win_any;
   logic [7:0]        cur_stat;
   logic              fifo_on;

   uart_irq_fcr #(.W(FCR_W)) u_fcr (
      .clk(clk), .rst_n(rst_n), .wr(fcr_wr), .wdata(fcr_wdata), .q(fcr_q)
   );
   assign fifo_on = fcr_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) tx_prev <= 1'b0;
      else        tx_prev <= tx_empty;
   end

   // pending vector in rank order
   assign pend[SRC_LINE]  = line_err   & int_en[SRC_LINE];
   assign pend[SRC_RXTO]  = rx_timeout & int_en[SRC_RXTO];
   assign pend[SRC_RXRDY] = rx_ready   & int_en[SRC_RXRDY];
   assign pend[SRC_TXRDY] = ev_q[EV_TX] & int_en[SRC_TXRDY];
   assign pend[SRC_MODEM] = modem_chg  & int_en[SRC_MODEM];
   assign pend[SRC_GPIN]  = gpin_chg   & int_en[SRC_GPIN];
   assign pend[SRC_XCHR]  = (ev_q[EV_XOFF] | ev_q[EV_SPC]) & enh_en & int_en[SRC_XCHR];
   assign pend[SRC_FLOW]  = ev_q[EV_FLOW] & enh_en & int_en[SRC_FLOW];

   uart_irq_prio #(.N(NSRC)) u_prio (
      .req(pend), .grant(grant), .idx(win_idx), .any(win_any)
   );

   assign cur_stat = {fifo_on, fifo_on, src_code(win_any, win_idx)};

   // event set / clear rules
   assign ev_set[EV_TX]   = tx_empty & ~tx_prev;
   assign ev_clr[EV_TX]   = stat_rd & grant[SRC_TXRDY];
   assign ev_set[EV_XOFF] = xoff_hit & enh_en & int_en[SRC_XCHR];
   assign ev_clr[EV_XOFF] = xon_hit;
   assign ev_set[EV_SPC]  = spchr_hit & enh_en & int_en[SRC_XCHR];
   assign ev_clr[EV_SPC]  = stat_rd & grant[SRC_XCHR];
   assign ev_set[EV_FLOW] = flow_deassert & enh_en;
   assign ev_clr[EV_FLOW] = stat_rd & grant[SRC_FLOW];

   for (genvar e = 0; e < NEV; e++) begin : g_evt
      uart_irq_evt u_evt (
         .clk(clk), .rst_n(rst_n), .set_i(ev_set[e]), .clr_i(ev_clr[e]), .q_o(ev_q[e])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       isr_q <= 8'h01;
      else if (stat_rd) isr_q <= cur_stat;
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |pend;
      end
   end else begin : g_irq_comb
      assign irq = |pend;
      assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !irq |-> cur_stat[0]);
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> $stable(isr_q));

   assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd && grant[SRC_TXRDY] && !(tx_empty && !tx_prev) |=> !ev_q[EV_TX]);

   assert_xoff_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q[EV_XOFF] && !xon_hit |=> ev_q[EV_XOFF]);

   assert_flow_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enh_en && !ev_q[EV_FLOW] |=> !ev_q[EV_FLOW]);
endmodule

// File: tb/uart_irq_status_tb.sv
module uart_irq_status_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       line_err, rx_timeout, rx_ready, tx_empty, modem_chg, gpin_chg;
   logic       xoff_hit, spchr_hit, flow_deassert, xon_hit;
   logic [7:0] int_en;
   logic       enh_en, stat_rd, fcr_wr;
   logic [7:0] fcr_wdata;
   logic [7:0] isr_q, fcr_q;
   logic       irq;

   always #4 clk = ~clk;

   uart_irq_status u_dut (
      .clk(clk), .rst_n(rst_n), .line_err(line_err), .rx_timeout(rx_timeout),
      .rx_ready(rx_ready), .tx_empty(tx_empty), .modem_chg(modem_chg), .gpin_chg(gpin_chg),
      .xoff_hit(xoff_hit), .spchr_hit(spchr_hit), .flow_deassert(flow_deassert),
      .xon_hit(xon_hit), .int_en(int_en), .enh_en(enh_en), .stat_rd(stat_rd),
      .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .isr_q(isr_q), .fcr_q(fcr_q), .irq(irq)
   );

   int    total = 0;
   int    bad = 0;
   string tag = "R1";
   bit    done = 1'b0;

   // behavioural reference state
   bit       m_tx, m_xo, m_sp, m_fl, m_prev;
   bit [7:0] m_isr, m_fcr;

   function automatic bit [7:0] pend_now();
      bit [7:0] p;
      p[0] = line_err   && int_en[0];
      p[1] = rx_timeout && int_en[1];
      p[2] = rx_ready   && int_en[2];
      p[3] = m_tx       && int_en[3];
      p[4] = modem_chg  && int_en[4];
      p[5] = gpin_chg   && int_en[5];
      p[6] = (m_xo || m_sp) && enh_en && int_en[6];
      p[7] = m_fl && enh_en && int_en[7];
      return p;
   endfunction

   function automatic int top_idx(bit [7:0] p);
      for (int i = 0; i < 8; i++) if (p[i]) return i;
      return -1;
   endfunction

   function automatic bit [5:0] code_of(int i);
      case (i)
         0: return 6'h06;
         1: return 6'h0C;
         2: return 6'h04;
         3: return 6'h02;
         4: return 6'h00;
         5: return 6'h30;
         6: return 6'h10;
         7: return 6'h20;
         default: return 6'h01;
      endcase
   endfunction

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", r, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit [7:0] p;
      int       w;
      if (!rst_n) begin
         m_tx = 0; m_xo = 0; m_sp = 0; m_fl = 0; m_prev = 0;
         m_isr = 8'h01; m_fcr = 8'h00;
      end else begin
         p = pend_now();
         w = top_idx(p);
         if (stat_rd) m_isr = {m_fcr[0], m_fcr[0], code_of(w)};
         // clears first, then sets
         if (stat_rd && w == 3) m_tx = 0;
         if (stat_rd && w == 6) m_sp = 0;
         if (stat_rd && w == 7) m_fl = 0;
         if (xon_hit) m_xo = 0;
         if (tx_empty && !m_prev) m_tx = 1;
         if (xoff_hit && enh_en && int_en[6]) m_xo = 1;
         if (spchr_hit && enh_en && int_en[6]) m_sp = 1;
         if (flow_deassert && enh_en) m_fl = 1;
         m_prev = tx_empty;
         if (fcr_wr) begin
            m_fcr[0] = fcr_wdata[0];
            if (fcr_wdata[0]) m_fcr[7:1] = fcr_wdata[7:1];
         end
      end
      #1;
      if (rst_n && !done) begin
         chk({tag, " isr"}, isr_q, m_isr);
         chk({tag, " fcr"}, fcr_q, m_fcr);
         chk({tag, " irq"}, irq, |pend_now());
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic rd_expect(string r, logic [7:0] exp);
      stat_rd = 1'b1;
      step();
      stat_rd = 1'b0;
      chk(r, isr_q, exp);
   endtask

   initial begin
      #(8 * 150000);
      $display("FAIL watchdog expired");
      total++;
      bad++;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 0;
      {line_err, rx_timeout, rx_ready, tx_empty, modem_chg, gpin_chg} = '0;
      {xoff_hit, spchr_hit, flow_deassert, xon_hit} = '0;
      int_en = 8'h00; enh_en = 0; stat_rd = 0; fcr_wr = 0; fcr_wdata = 8'h00;
      repeat (3) step();
      rst_n = 1;
      step();
      // R1 reset state
      chk("R1 isr", isr_q, 8'h01);
      chk("R1 fcr", fcr_q, 8'h00);
      chk("R1 irq", irq, 1'b0);

      // R2 / R4 priority walk over level sources
      tag = "R2"; int_en = 8'hFF; enh_en = 1;
      {line_err, rx_timeout, rx_ready, modem_chg, gpin_chg} = 5'b11111;
      step();
      rd_expect("R2 line", 8'h06);
      line_err = 0;   rd_expect("R2 rxto", 8'h0C);
      rx_timeout = 0; rd_expect("R2 rxrdy", 8'h04);
      rx_ready = 0;   rd_expect("R4 modem", 8'h00);
      modem_chg = 0;  rd_expect("R4 gpin", 8'h30);
      gpin_chg = 0;   rd_expect("R4 none", 8'h01);
      chk("R4 irq low", irq, 1'b0);

      // R3 enable gating
      tag = "R3"; int_en = 8'h00; rx_ready = 1; step();
      chk("R3 irq masked", irq, 1'b0);
      rd_expect("R3 masked", 8'h01);
      int_en = 8'hFF; step();
      chk("R3 irq on", irq, 1'b1);
      rx_ready = 0; step();

      // R5 transmit event and read/set collision
      tag = "R5"; tx_empty = 1; step();
      chk("R5 irq", irq, 1'b1);
      rd_expect("R5 tx", 8'h02);
      rd_expect("R5 cleared", 8'h01);
      tx_empty = 0; step();
      tx_empty = 1; step();
      tx_empty = 0; step();
      tx_empty = 1; stat_rd = 1; step();
      stat_rd = 0;
      chk("R5 collide read", isr_q, 8'h02);
      rd_expect("R5 kept", 8'h02);
      rd_expect("R5 gone", 8'h01);

      // R6 Xoff
      tag = "R6"; enh_en = 0; xoff_hit = 1; step(); xoff_hit = 0; enh_en = 1; step();
      rd_expect("R6 gated", 8'h01);
      xoff_hit = 1; step(); xoff_hit = 0;
      rd_expect("R6 xoff", 8'h10);
      rd_expect("R6 held", 8'h10);
      xon_hit = 1; step(); xon_hit = 0;
      rd_expect("R6 xon", 8'h01);

      // R7 special character
      tag = "R7"; spchr_hit = 1; step(); spchr_hit = 0;
      rd_expect("R7 spc", 8'h10);
      rd_expect("R7 cleared", 8'h01);

      // R8 flow change
      tag = "R8"; enh_en = 0; flow_deassert = 1; step(); flow_deassert = 0; enh_en = 1; step();
      rd_expect("R8 gated", 8'h01);
      flow_deassert = 1; step(); flow_deassert = 0;
      rd_expect("R8 flow", 8'h20);
      rd_expect("R8 cleared", 8'h01);

      // R2 latched ranks
      tag = "R2"; flow_deassert = 1; spchr_hit = 1; step(); flow_deassert = 0; spchr_hit = 0;
      rd_expect("R2 xchr first", 8'h10);
      rd_expect("R2 flow next", 8'h20);
      rd_expect("R2 empty", 8'h01);

      // R9 capture and FIFO bits
      tag = "R9"; fcr_wr = 1; fcr_wdata = 8'h01; step(); fcr_wr = 0;
      rd_expect("R9 fifo bits", 8'hC1);
      rx_ready = 1; step(); step();
      chk("R9 stable", isr_q, 8'hC1);
      rx_ready = 0; step();

      // R10 FIFO control write rule
      tag = "R10"; fcr_wr = 1; fcr_wdata = 8'hA5; step();
      chk("R10 full write", fcr_q, 8'hA5);
      fcr_wdata = 8'h5A; step(); fcr_wr = 0;
      chk("R10 upper kept", fcr_q, 8'hA4);
      rd_expect("R10 fifo off", 8'h01);

      // random mix against the model
      tag = "RND";
      for (int n = 0; n < 4000; n++) begin
         line_err      = ($urandom % 8) == 0;
         rx_timeout    = ($urandom % 8) == 0;
         rx_ready      = ($urandom % 6) == 0;
         tx_empty      = ($urandom % 2) == 0;
         modem_chg     = ($urandom % 8) == 0;
         gpin_chg      = ($urandom % 8) == 0;
         xoff_hit      = ($urandom % 10) == 0;
         spchr_hit     = ($urandom % 10) == 0;
         flow_deassert = ($urandom % 10) == 0;
         xon_hit       = ($urandom % 12) == 0;
         stat_rd       = ($urandom % 3) == 0;
         fcr_wr        = ($urandom % 16) == 0;
         fcr_wdata     = 8'($urandom);
         if (($urandom % 32) == 0) int_en = 8'($urandom);
         if (($urandom % 32) == 0) enh_en = ~enh_en;
         step();
      end
      {stat_rd, fcr_wr, xoff_hit, spchr_hit, flow_deassert, xon_hit} = '0;
      step();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule